// File: doc/BRIEF.md
# DS3 Transmit Overhead Generator

This block sits in the transmit path of a DS3 line interface and writes the overhead bits of an M23 multiframe into a serial bit stream. It tracks where each accepted bit falls in the 4760-bit multiframe. The multiframe is seven subframes, each of eight blocks, and each block is one overhead bit followed by 84 payload bits. The block replaces the framing, multiframe, alarm, parity and stuffing-control overhead slots with generated values. Each class of generation can be switched on or off.

After generation, an external serial overhead port can override any overhead slot. The block drives two strobes for that port: one marks the first bit of the multiframe and one marks every overhead slot. In the same cycle the port answers with an enable and a data bit. On the two parity slots the external bit does not replace the generated value. It is XORed onto it as an error mask, which lets a test host inject parity errors. The parity carried in each multiframe is the modulo-2 sum of all payload bits of the previous output multiframe.

Top module: `ds3_ohgen`

## Requirements
- R1: An accepted bit (`in_valid`=1) produces `out_valid`=1 and its `out_bit` exactly one cycle later. `oh_slot` is high when the current input bit is an overhead slot, which happens every 85th bit. `frame_sof` is high on the first overhead slot of the 4760-bit multiframe and is also high after reset.
- R2: Payload bits (the 84 bits after each overhead slot) pass to the output unchanged.
- R3: With `frm_en`=1, the overhead bits of blocks 1, 3, 5 and 7 (counting blocks 0..7 within a subframe) are the framing bits 1, 0, 0, 1. The block-0 overhead bits of subframes 4, 5 and 6 (counting subframes 0..6) are the multiframe bits 0, 1, 0.
- R4: With `frm_en`=1, the block-0 overhead bits of subframes 0 and 1 are the alarm bits. Both are 0 while any condition with `alm_stat[i]` and `alm_mask[i]` both set is present, and 1 otherwise. The bit order is [0] loss of signal, [1] severely errored frame, [2] loss of frame, [3] alarm indication signal.
- R5: The block-0 overhead bits of subframes 2 and 3 are the parity bits. Both equal the XOR of all 4704 payload bits of the previous output multiframe. In the first multiframe after reset they are 0.
- R6: Parity is generated when `pgen_en`=1 or `frm_en`=1. With both at 0, the parity slots carry the input bit.
- R7: With `frm_en`=0, every non-parity overhead slot carries the input bit.
- R8: The overhead bits of blocks 2, 4 and 6 are the stuffing-control bits. They are 0 when `frm_en`=1 and `cgen_en`=1, and carry the input bit otherwise.
- R9: When `oh_en`=1 on a non-parity overhead slot, the output is `oh_bit`, whatever the generation enables are.
- R10: When `oh_en`=1 on a parity slot, the output is the value the slot would otherwise carry, XORed with `oh_bit`.
- R11: `oh_en` and `oh_bit` have no effect on payload bits.
- R12: When `in_valid`=0, the multiframe position holds and `out_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit clock enable |
| in_bit | input | 1 | Serial input bit |
| frm_en | input | 1 | Framing, multiframe, alarm and parity generation enable |
| pgen_en | input | 1 | Parity generation enable, effective even with framing off |
| cgen_en | input | 1 | Stuffing-control bit generation enable |
| alm_mask | input | 4 | Per-alarm enable for driving the alarm bits |
| alm_stat | input | 4 | Alarm conditions present |
| oh_en | input | 1 | External overhead enable for the current slot |
| oh_bit | input | 1 | External overhead bit or parity error mask |
| out_bit | output | 1 | Serial output bit |
| out_valid | output | 1 | Output bit valid |
| frame_sof | output | 1 | Current input bit is the first bit of the multiframe |
| oh_slot | output | 1 | Current input bit is an overhead slot |

## Verification
The bench feeds several multiframes of random data. Each multiframe uses a different mix of framing, parity and stuffing-control enables and alarm masks, and some idle gaps are inserted along the way. Parity is followed across multiframe boundaries: a design that used the current multiframe, or that counted overhead bits in the sum, shows wrong parity bits from the second multiframe onward. Random external overhead enables land on payload, parity and other slots. A design that replaced the parity bits instead of masking them, or that let the port touch payload, shows mismatches on exactly those bits. The idle gaps expose a position counter that advances without a valid bit, because the strobes and every later slot then shift.

// File: rtl/ds3_ohgen.sv
module ds3_ohgen #(
  parameter int SUBFRAMES  = 7,
  parameter int BLOCKS     = 8,
  parameter int BLOCK_BITS = 85
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_bit,
  input  logic       frm_en,
  input  logic       pgen_en,
  input  logic       cgen_en,
  input  logic [3:0] alm_mask,
  input  logic [3:0] alm_stat,
  input  logic       oh_en,
  input  logic       oh_bit,
  output logic       out_bit,
  output logic       out_valid,
  output logic       frame_sof,
  output logic       oh_slot
);
  localparam int SW = $clog2(SUBFRAMES);
  localparam int BW = $clog2(BLOCKS);
  localparam int KW = $clog2(BLOCK_BITS);

  logic [SW-1:0] sf_q;
  logic [BW-1:0] blk_q;
  logic [KW-1:0] bit_q;
  logic          acc_q, par_q;
  logic          gen, nxt;

  wire last_bit = bit_q == KW'(BLOCK_BITS - 1);
  wire last_blk = blk_q == BW'(BLOCKS - 1);
  wire last_sf  = sf_q == SW'(SUBFRAMES - 1);
  wire last_all = last_bit && last_blk && last_sf;

  assign oh_slot   = bit_q == '0;
  assign frame_sof = oh_slot && blk_q == '0 && sf_q == '0;

  wire first_oh = oh_slot && blk_q == '0;
  wire slot_x   = first_oh && sf_q < SW'(2);
  wire slot_p   = first_oh && (sf_q == SW'(2) || sf_q == SW'(3));
  wire slot_m   = first_oh && sf_q >= SW'(4);
  wire slot_f   = oh_slot && blk_q[0];
  wire slot_c   = oh_slot && blk_q != '0 && !blk_q[0];

  wire x_val = ~|(alm_stat & alm_mask);
  wire m_val = sf_q == SW'(5);
  wire f_val = blk_q == BW'(1) || blk_q == BW'(7);

  always_comb begin
    gen = in_bit;
    if (slot_p) begin
      if (pgen_en || frm_en) gen = par_q;
    end else if (frm_en) begin
      if (slot_x)                gen = x_val;
      else if (slot_m)           gen = m_val;
      else if (slot_f)           gen = f_val;
      else if (slot_c && cgen_en) gen = 1'b0;
    end
  end

  always_comb begin
    nxt = gen;
    if (oh_en && oh_slot) nxt = slot_p ? (gen ^ oh_bit) : oh_bit;
  end

  wire acc_nxt = acc_q ^ (!oh_slot && nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sf_q      <= '0;
      blk_q     <= '0;
      bit_q     <= '0;
      acc_q     <= 1'b0;
      par_q     <= 1'b0;
      out_bit   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_bit <= nxt;
        bit_q   <= last_bit ? '0 : bit_q + 1'b1;
        if (last_bit) begin
          blk_q <= last_blk ? '0 : blk_q + 1'b1;
          if (last_blk) sf_q <= last_sf ? '0 : sf_q + 1'b1;
        end
        if (last_all) begin
          par_q <= acc_nxt;
          acc_q <= 1'b0;
        end else begin
          acc_q <= acc_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/ds3_ohgen_chk.sv
module ds3_ohgen_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_bit,
  input logic frm_en,
  input logic pgen_en,
  input logic oh_en,
  input logic oh_bit,
  input logic out_bit,
  input logic out_valid,
  input logic frame_sof,
  input logic oh_slot,
  input logic slot_p
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R1
  AST_SOF_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sof |-> oh_slot);  // R1
  AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !oh_slot |=> out_bit == $past(in_bit));  // R2
  AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !frm_en && !pgen_en && !oh_en |=> out_bit == $past(in_bit));  // R7
  AST_OH_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && oh_slot && oh_en && !slot_p |=> out_bit == $past(oh_bit));  // R9
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R12
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(frame_sof) && $stable(oh_slot));  // R12
endmodule

bind ds3_ohgen ds3_ohgen_chk u_chk (.*);

// File: tb/sim_ds3_ohgen.sv
module sim_ds3_ohgen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0;
  logic frm_en = 1'b0, pgen_en = 1'b0, cgen_en = 1'b0;
  logic [3:0] alm_mask = 4'h0, alm_stat = 4'h0;
  logic oh_en = 1'b0, oh_bit = 1'b0;
  logic out_bit, out_valid, frame_sof, oh_slot;

  int n_cmp = 0, n_bad = 0;
  logic  expq[$];
  string tagq[$];
  int m_sf = 0, m_blk = 0, m_bit = 0;
  logic m_acc = 1'b0, m_par = 1'b0;

  always #4 clk = ~clk;

  ds3_ohgen u0 (.*);

  task automatic chk(input string r, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", r, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) chk("R12 unexpected out_valid", 1'b1, 1'b0);
      else begin
        logic e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(t, out_bit, e);
      end
    end
  end

  task automatic drive(input logic d, input logic ohe, input logic ohb);
    logic e;
    string t;
    logic base;
    @(negedge clk);
    in_valid = 1'b1; in_bit = d; oh_en = ohe; oh_bit = ohb;
    chk("R1 frame_sof", frame_sof, m_sf == 0 && m_blk == 0 && m_bit == 0);
    chk("R1 oh_slot", oh_slot, m_bit == 0);
    if (m_bit != 0) begin
      e = d; t = ohe ? "R11 payload with oh_en" : "R2 payload";
      m_acc ^= e;
    end else if (m_blk == 0 && (m_sf == 2 || m_sf == 3)) begin
      base = (pgen_en || frm_en) ? m_par : d;
      e = base ^ (ohe & ohb);
      t = ohe ? "R10 parity mask" : (frm_en ? "R5 parity" : "R6 parity");
    end else begin
      if (!frm_en) begin base = d; t = "R7 pass"; end
      else if (m_blk == 0 && m_sf < 2) begin base = ~|(alm_stat & alm_mask); t = "R4 alarm bit"; end
      else if (m_blk == 0) begin base = (m_sf == 5); t = "R3 M bit"; end
      else if (m_blk % 2 == 1) begin base = (m_blk == 1 || m_blk == 7); t = "R3 F bit"; end
      else begin base = cgen_en ? 1'b0 : d; t = "R8 C bit"; end
      e = ohe ? ohb : base;
      if (ohe) t = "R9 overhead override";
    end
    expq.push_back(e);
    tagq.push_back(t);
    if (m_bit == 84) begin
      m_bit = 0;
      if (m_blk == 7) begin
        m_blk = 0;
        if (m_sf == 6) begin m_sf = 0; m_par = m_acc; m_acc = 1'b0; end
        else m_sf++;
      end else m_blk++;
    end else m_bit++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; oh_en = 1'b0;
  endtask

  task automatic run_frame(input int ohe_rate, input int gap_rate);
    for (int i = 0; i < 4760; i++) begin
      if (gap_rate != 0 && ($urandom % gap_rate) == 0) idle();
      drive(1'(($urandom)), ohe_rate != 0 && ($urandom % ohe_rate) == 0, 1'($urandom));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", out_valid, 1'b0);
    chk("R1 reset out_bit", out_bit, 1'b0);
    chk("R1 reset frame_sof", frame_sof, 1'b1);
    rst_n = 1'b1;
    frm_en = 1; pgen_en = 0; cgen_en = 1; alm_mask = 4'hF; alm_stat = 4'h0;
    run_frame(0, 0);
    alm_stat = 4'b0100; cgen_en = 0;
    run_frame(0, 0);
    frm_en = 0; pgen_en = 1;
    run_frame(0, 0);
    pgen_en = 0;
    run_frame(0, 7);
    frm_en = 1; cgen_en = 1;
    run_frame(3, 0);
    alm_mask = 4'b0011; alm_stat = 4'b1100; pgen_en = 1;
    run_frame(0, 0);
    idle();
    repeat (4) @(negedge clk);
    chk("R12 queue drained", expq.size() == 0, 1'b1);
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    summary();
    $finish;
  end
endmodule